// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

This block is one timer channel that generates two digital waveforms, `out_a` and `out_b`, from a single up-counter. The counter runs from a selectable time base: the system clock divided by 2, 8, 32 or 128, or pulses from a separate slow time base. It counts from zero up to the value in the period compare register and then returns to zero, so both outputs share one period.

Each output has a duty compare register. Each output also has three programmable actions: one for its duty compare, one for the period compare and one for a software trigger. An action can set, clear or toggle the output, or leave it alone. With these actions the channel can produce a PWM of either polarity, a square wave, or a fixed level that software sets with a trigger.

Software programs the channel through a synchronous write strobe. A command word starts the clock, stops it or issues a software trigger, and one command may combine these.

Top module: `wave_timer_chan`

## Requirements
- R1: After reset both outputs are low, `count_o` is 0 and `running_o` is 0.
- R2: Write address 0 loads the mode word. Its bits [2:0] select the time base. Codes 0, 1, 2 and 3 advance the counter once every 2, 8, 32 and 128 system clocks. Code 4 advances it once per cycle in which `slow_tick` is high. Codes 5 to 7 never advance it. The first advance comes N system clocks after the write that starts the clock, where N is the divide ratio.
- R3: While running, the counter adds one on each advance. On an advance where it equals the period compare value (address 3), it goes to 0 instead.
- R4: Mode bits [4:3], [6:5] and [8:7] are the actions of `out_a` for compare A (address 1), for the period compare and for the software trigger. Bits [10:9], [12:11] and [14:13] are the same actions for `out_b`, whose duty compare is compare B (address 2). The action codes are 00 none, 01 set, 10 clear and 11 toggle. A compare acts on the counter value present at an advance, and the output changes at the same clock edge as the counter.
- R5: A write to address 4 is a command. Bit 0 enables the clock, bit 1 disables it and wins over bit 0, and bit 2 is a software trigger. The trigger clears the counter and the prescaler to 0 and applies the trigger action of both outputs at that edge.
- R6: When several events hit one output at the same edge, only one action is taken. The software trigger wins over the period compare, and the period compare wins over the duty compare.
- R7: While the clock is disabled, the counter and both outputs hold their values. A later enable without a trigger resumes counting from the held value.
- R8: An output whose compare actions are all none keeps the level the software trigger gave it for as long as the channel runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulses from the slow time base |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address: 0 mode, 1 compare A, 2 compare B, 3 period, 4 command |
| wr_data | input | CNT_W | Write data |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |
| count_o | output | CNT_W | Current counter value |
| running_o | output | 1 | Clock is enabled |

## Verification
The hardest case to reach from the ports is a software trigger that lands on the same edge as a period-compare advance. Only then can a wrong priority order show up. The stimulus starts the counter with a trigger, so the prescaler phase is known, and counts edges from that write to the advance at which the counter sits on the period value. It then times the second command write so that the strobe is sampled on exactly that edge. The duty-versus-period case is reached in the same way, by giving the duty compare and the period compare the same value. The toggle action is used so that each possible winner leaves a different level on the output.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  // Prescaler counter width, sized for the largest divide ratio (128).
  localparam int PRE_W = 7;
  localparam int MODE_W = 15;
  localparam int NUM_OUT = 2;

  // Write address map.
  localparam logic [2:0] ADR_MODE = 3'd0;
  localparam logic [2:0] ADR_CMPA = 3'd1;
  localparam logic [2:0] ADR_CMPB = 3'd2;
  localparam logic [2:0] ADR_PER  = 3'd3;
  localparam logic [2:0] ADR_CMD  = 3'd4;

  // Command bits.
  localparam int CMD_EN   = 0;
  localparam int CMD_DIS  = 1;
  localparam int CMD_TRIG = 2;

  // Time base select code for the slow time base.
  localparam logic [2:0] SEL_SLOW = 3'd4;

  // Low bit of each output's action group in the mode word.
  localparam int ACT_BASE_A = 3;
  localparam int ACT_BASE_B = 9;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  // New output level after an action is applied.
  function automatic logic apply_act(act_e a, logic cur);
    case (a)
      ACT_SET: apply_act = 1'b1;
      ACT_CLR: apply_act = 1'b0;
      ACT_TGL: apply_act = ~cur;
      default: apply_act = cur;
    endcase
  endfunction

  // Last prescaler index for divide codes 0..3: 1, 7, 31, 127.
  function automatic logic [PRE_W-1:0] div_last(logic [1:0] code);
    logic [PRE_W:0] ratio;
    ratio = (PRE_W+1)'(2) << (2 * code);
    div_last = PRE_W'(ratio - 1'b1);
  endfunction
endpackage

// File: rtl/wtc_prescale.sv
module wtc_prescale
  import wtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [2:0] sel,
  input  logic       slow_tick,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic             is_div;
  logic             at_last;

  always_comb begin
    is_div  = (sel < 3'd4);
    at_last = (pre_q == div_last(sel[1:0]));
    if (!run)        tick = 1'b0;
    else if (is_div) tick = at_last;
    else             tick = (sel == SEL_SLOW) && slow_tick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                   pre_q <= '0;
    else if (!run || restart || !is_div || at_last) pre_q <= '0;
    else                                          pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wtc_counter.sv
module wtc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             match_per
);
  assign match_per = (cnt == period);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (clear)    cnt <= '0;
    else if (tick)     cnt <= match_per ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/wtc_out_unit.sv
module wtc_out_unit
  import wtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sw_trig,
  input  logic             match_per,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  input  act_e             act_duty,
  input  act_e             act_per,
  input  act_e             act_trig,
  output logic             match_duty,
  output logic             wave
);
  logic nxt;

  assign match_duty = (cnt == duty);

  // Trigger first, then period compare, then duty compare.
  always_comb begin
    if (sw_trig)                 nxt = apply_act(act_trig, wave);
    else if (tick && match_per)  nxt = apply_act(act_per, wave);
    else if (tick && match_duty) nxt = apply_act(act_duty, wave);
    else                         nxt = wave;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wave <= 1'b0;
    else        wave <= nxt;
  end
endmodule

// File: rtl/wave_timer_chan.sv
module wave_timer_chan
  import wtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             out_a,
  output logic             out_b,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o
);
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  duty_q [NUM_OUT];
  logic [CNT_W-1:0]  per_q;
  logic              run_q;

  logic              cmd_wr;
  logic              sw_trig;
  logic              tick;
  logic              match_per;
  logic [CNT_W-1:0]  cnt;
  logic [NUM_OUT-1:0] wave;
  logic [NUM_OUT-1:0] match_duty;

  assign cmd_wr  = wr_en && (wr_addr == ADR_CMD);
  assign sw_trig = cmd_wr && wr_data[CMD_TRIG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      per_q  <= '0;
      run_q  <= 1'b0;
      for (int i = 0; i < NUM_OUT; i++) duty_q[i] <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_MODE: mode_q    <= wr_data[MODE_W-1:0];
        ADR_CMPA: duty_q[0] <= wr_data;
        ADR_CMPB: duty_q[1] <= wr_data;
        ADR_PER:  per_q     <= wr_data;
        ADR_CMD: begin
          // Disable wins over enable when both are set.
          if (wr_data[CMD_DIS])     run_q <= 1'b0;
          else if (wr_data[CMD_EN]) run_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  wtc_prescale u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .restart   (sw_trig),
    .sel       (mode_q[2:0]),
    .slow_tick (slow_tick),
    .tick      (tick)
  );

  wtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .clear     (sw_trig),
    .period    (per_q),
    .cnt       (cnt),
    .match_per (match_per)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    localparam int BASE = (g == 0) ? ACT_BASE_A : ACT_BASE_B;
    wtc_out_unit #(.CNT_W(CNT_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .sw_trig    (sw_trig),
      .match_per  (match_per),
      .cnt        (cnt),
      .duty       (duty_q[g]),
      .act_duty   (act_e'(mode_q[BASE +: 2])),
      .act_per    (act_e'(mode_q[BASE+2 +: 2])),
      .act_trig   (act_e'(mode_q[BASE+4 +: 2])),
      .match_duty (match_duty[g]),
      .wave       (wave[g])
    );
  end

  assign out_a     = wave[0];
  assign out_b     = wave[1];
  assign count_o   = cnt;
  assign running_o = run_q;
endmodule

// File: rtl/wtc_chk.sv
module wtc_chk
  import wtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             sw_trig,
  input logic             match_per,
  input logic             running,
  input logic [CNT_W-1:0] count,
  input logic             out_a,
  input logic             out_b,
  input logic [MODE_W-1:0] mode
);
  // R2
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !tick);

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sw_trig && !match_per) |=> (count == CNT_W'($past(count) + 1'b1)));

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sw_trig && match_per) |=> (count == '0));

  // R5
  trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_trig |=> (count == '0));

  // R6
  trig_set_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_trig && mode[ACT_BASE_A+4 +: 2] == ACT_SET) |=> out_a);

  // R4
  per_set_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match_per && !sw_trig && mode[ACT_BASE_A+2 +: 2] == ACT_SET) |=> out_a);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !sw_trig) |=> ($stable(count) && $stable(out_a) && $stable(out_b)));
endmodule

bind wave_timer_chan wtc_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .sw_trig   (sw_trig),
  .match_per (match_per),
  .running   (run_q),
  .count     (cnt),
  .out_a     (out_a),
  .out_b     (out_b),
  .mode      (mode_q)
);

// File: tb/wave_timer_chan_tb_top.sv
module wave_timer_chan_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         slow_tick = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         out_a, out_b, running_o;
  logic [W-1:0] count_o;

  int n_cmp = 0;
  int n_bad = 0;
  int rel = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wave_timer_chan #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_a(out_a), .out_b(out_b), .count_o(count_o), .running_o(running_o)
  );

  // Action codes: 0 none, 1 set, 2 clear, 3 toggle
  function automatic logic [W-1:0] mk_mode(int sel, int ad, int ac, int at,
                                           int bd, int bc, int bt);
    logic [14:0] m;
    m = {bt[1:0], bc[1:0], bd[1:0], at[1:0], ac[1:0], ad[1:0], sel[2:0]};
    return W'(m);
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; the write is sampled at the next rising
  // edge (E0) and the task returns at the falling edge after it.
  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    rel = 0;
  endtask

  task automatic go_to(int k);
    repeat (k - rel) @(negedge clk);
    rel = k;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "out_a", out_a, 0);
    check("R1", "out_b", out_b, 0);
    check("R1", "count", count_o, 0);
    check("R1", "running", running_o, 0);
  endtask

  // Divide by 2 (code 0): the count becomes k at edge 2k.
  // A: normal polarity, duty 3, period 7 -> clears at edge 8, sets at edge 16.
  // B: inverted polarity, duty 2 -> sets at edge 6, clears at edge 16.
  task automatic t_pwm();
    do_reset();
    wr(3'd0, mk_mode(0, 2, 1, 1, 1, 2, 2));
    wr(3'd1, 16'd3);
    wr(3'd2, 16'd2);
    wr(3'd3, 16'd7);
    wr(3'd4, 16'b101);
    check("R5", "out_a after trig", out_a, 1);
    check("R5", "out_b after trig", out_b, 0);
    check("R5", "count after trig", count_o, 0);
    go_to(5);  check("R4", "out_b e5", out_b, 0);
    go_to(6);  check("R4", "out_b e6", out_b, 1);
               check("R3", "count e6", count_o, 3);
    go_to(7);  check("R4", "out_a e7", out_a, 1);
    go_to(8);  check("R4", "out_a e8", out_a, 0);
    go_to(15); check("R3", "count e15", count_o, 7);
               check("R4", "out_a e15", out_a, 0);
    go_to(16); check("R3", "count wrap e16", count_o, 0);
               check("R4", "out_a e16", out_a, 1);
               check("R4", "out_b e16", out_b, 0);
  endtask

  // Divide ratio for code s is 2 << 2s; the first step comes at edge N.
  task automatic t_prescale();
    for (int s = 0; s < 4; s++) begin
      int n = 2 << (2 * s);
      do_reset();
      wr(3'd0, mk_mode(s, 0, 0, 0, 0, 0, 0));
      wr(3'd3, 16'd100);
      wr(3'd4, 16'b101);
      go_to(n - 1); check("R2", $sformatf("code %0d before", s), count_o, 0);
      go_to(n);     check("R2", $sformatf("code %0d first", s), count_o, 1);
      go_to(2 * n); check("R2", $sformatf("code %0d second", s), count_o, 2);
    end
  endtask

  task automatic pulse_slow();
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_slow();
    do_reset();
    wr(3'd0, mk_mode(4, 0, 0, 0, 0, 0, 0));
    wr(3'd3, 16'd9);
    wr(3'd4, 16'b101);
    repeat (10) @(negedge clk);
    check("R2", "slow no pulse", count_o, 0);
    pulse_slow();
    check("R2", "slow one pulse", count_o, 1);
    pulse_slow(); pulse_slow(); pulse_slow();
    check("R2", "slow four pulses", count_o, 4);
  endtask

  // Duty compare equals period compare (3); the period action (set)
  // must beat the duty action (clear). A second trigger (toggle) lands on
  // the next period advance at edge 16 and must beat the period set.
  task automatic t_priority();
    do_reset();
    wr(3'd0, mk_mode(0, 2, 1, 3, 0, 0, 0));
    wr(3'd1, 16'd3);
    wr(3'd3, 16'd3);
    wr(3'd4, 16'b101);
    check("R6", "toggle from low", out_a, 1);
    go_to(8);  check("R6", "period over duty", out_a, 1);
               check("R3", "wrap e8", count_o, 0);
    go_to(15);
    wr(3'd4, 16'b100);
    check("R6", "trigger over period", out_a, 0);
    check("R5", "count cleared", count_o, 0);
  endtask

  task automatic t_fixed();
    do_reset();
    wr(3'd0, mk_mode(0, 0, 0, 1, 0, 0, 2));
    wr(3'd1, 16'd0);
    wr(3'd2, 16'd5);
    wr(3'd3, 16'd5);
    wr(3'd4, 16'b101);
    go_to(5);  check("R8", "A high e5", out_a, 1);
    go_to(12); check("R8", "A high e12", out_a, 1);
               check("R8", "B low e12", out_b, 0);
    go_to(13); check("R8", "A high e13", out_a, 1);
    go_to(30); check("R8", "A high e30", out_a, 1);
               check("R8", "B low e30", out_b, 0);
  endtask

  // Period 1 with B toggling on the period compare: B changes at edges 4 and 8.
  task automatic t_toggle();
    do_reset();
    wr(3'd0, mk_mode(0, 0, 0, 0, 0, 3, 0));
    wr(3'd3, 16'd1);
    wr(3'd4, 16'b101);
    go_to(3); check("R4", "toggle e3", out_b, 0);
    go_to(4); check("R4", "toggle e4", out_b, 1);
    go_to(7); check("R4", "toggle e7", out_b, 1);
    go_to(8); check("R4", "toggle e8", out_b, 0);
  endtask

  task automatic t_disable();
    do_reset();
    wr(3'd0, mk_mode(0, 2, 1, 1, 0, 0, 3));
    wr(3'd1, 16'd3);
    wr(3'd3, 16'd7);
    wr(3'd4, 16'b101);
    check("R5", "B toggled by trig", out_b, 1);
    go_to(4);
    wr(3'd4, 16'b010);
    check("R7", "running off", running_o, 0);
    check("R7", "count held", count_o, 2);
    repeat (20) @(negedge clk);
    check("R7", "count held late", count_o, 2);
    check("R7", "A held late", out_a, 1);
    check("R7", "B held late", out_b, 1);
    wr(3'd4, 16'b011);
    check("R5", "dis wins over en", running_o, 0);
    wr(3'd4, 16'b001);
    check("R7", "running on", running_o, 1);
    go_to(1); check("R7", "resume e1", count_o, 2);
    go_to(2); check("R7", "resume e2", count_o, 3);
    wr(3'd4, 16'b110);
    check("R5", "stop+trig count", count_o, 0);
    check("R5", "stop+trig running", running_o, 0);
    check("R5", "stop+trig B toggled", out_b, 0);
    repeat (10) @(negedge clk);
    check("R7", "stopped after trig", count_o, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_pwm();
    t_prescale();
    t_slow();
    t_priority();
    t_fixed();
    t_toggle();
    t_disable();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule